// File: doc/BRIEF.md
# Multi-radix ASCII number parser

This block turns a stream of ASCII characters, delivered at most one per clock with a valid qualifier, into unsigned numeric results. Its usual source is a serial receiver feeding a command front end. Each token is classified by its opening characters:
- `0x` means hexadecimal.
- `0b` means binary.
- A leading `0` followed by further digits means octal.
- `1` to `9` means decimal.
- A lone `0` is zero.
- The two-character token `-1` is an "unspecified value" sentinel.

A token ends at a whitespace character. The parser then emits one registered strobe in the next cycle. On success, `done_o` rises with the value on `value_o`; for the sentinel, `minus_one_o` rises as well. On failure, `error_o` rises alone. A malformed token puts the parser in a discard state, and everything up to the next whitespace is thrown away. Leading and repeated whitespace produce nothing. The value register keeps the last good result until the next one.

Top module: `num_token_parser`

## Requirements
- R1: During and straight after reset, done_o, error_o and minus_one_o are low and value_o is zero.
- R2: A token of 1-9 followed by 0-9 is decimal. A lone "0" yields done_o with value 0.
- R3: "0x" followed by one or more of 0-9, a-f, A-F is parsed as hexadecimal.
- R4: A leading "0" followed by digits 0-7 is octal. An 8 or 9 in that position is an error.
- R5: "0b" followed by one or more 0/1 digits is binary. Any other digit after the prefix is an error.
- R6: The token "-1" yields done_o and minus_one_o together, with value_o all ones. A "-" followed by anything else is an error.
- R7: The whitespace codes are 0x20, 0x09, 0x0D and 0x0A. The result strobe appears in the cycle after the terminating whitespace is accepted and lasts one cycle.
- R8: After an illegal character, input is discarded up to the next whitespace. That whitespace raises error_o for one cycle and done_o stays low.
- R9: Prefix letters are case sensitive: "0X" and "0B" are errors.
- R10: A prefix followed directly by whitespace ("0x", "0b") is an error.
- R11: A token whose value exceeds 2^32-1 raises error_o at its terminating whitespace.
- R12: Whitespace with no pending token, and cycles with char_valid_i low, produce no strobe. A cycle with char_valid_i low leaves the token in progress intact.
- R13: done_o and error_o are never high together, and value_o changes only in a done_o cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | char_i carries a character this cycle |
| char_i | input | 8 | ASCII character |
| value_o | output | 32 | Last successfully parsed value |
| done_o | output | 1 | One-cycle strobe: token accepted |
| minus_one_o | output | 1 | With done_o: token was the -1 sentinel |
| error_o | output | 1 | One-cycle strobe: token rejected |

## Verification
Two things can share a cycle: the result strobe of one token and the acceptance of the first character of the next. The stimulus provokes this with single separators and no idle cycles between tokens, so the registered outputs of the finished token stand while the parser loads the new token's first digit. A behavioural model in the bench re-parses each completed token from a character queue. It predicts the strobes and the held value, and its prediction is compared with the outputs in every cycle. This catches a new token corrupting the reported value, or a missing strobe. Idle cycles carrying junk characters inside a token check that the partial value is left untouched.

// File: rtl/npar_pkg.sv
package npar_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ZERO, ST_PFX, ST_DIG, ST_NEG, ST_NEG1, ST_SKIP
  } npar_st_e;

  typedef enum logic [1:0] {RAD_DEC, RAD_HEX, RAD_OCT, RAD_BIN} npar_rad_e;

  function automatic logic is_ws(input logic [7:0] c);
    return (c == 8'h20) || (c == 8'h09) || (c == 8'h0D) || (c == 8'h0A);
  endfunction
endpackage

// File: rtl/npar_char_class.sv
module npar_char_class
  import npar_pkg::*;
(
  input  logic [7:0] char_i,
  input  npar_rad_e  rad_i,
  output logic       ws_o,
  output logic       nz_dec_o,
  output logic [3:0] val_o,
  output logic       fit_o
);
  logic is_dec, is_lo, is_up;
  logic [7:0] off;

  always_comb begin
    is_dec   = (char_i >= 8'h30) && (char_i <= 8'h39);
    is_lo    = (char_i >= 8'h61) && (char_i <= 8'h66);
    is_up    = (char_i >= 8'h41) && (char_i <= 8'h46);
    ws_o     = is_ws(char_i);
    nz_dec_o = is_dec && (char_i != 8'h30);
    off      = 8'h00;
    if (is_dec)     off = char_i - 8'h30;
    else if (is_lo) off = char_i - 8'h57;
    else if (is_up) off = char_i - 8'h37;
    val_o = off[3:0];
    unique case (rad_i)
      RAD_DEC: fit_o = is_dec;
      RAD_HEX: fit_o = is_dec || is_lo || is_up;
      RAD_OCT: fit_o = (char_i >= 8'h30) && (char_i <= 8'h37);
      default: fit_o = (char_i == 8'h30) || (char_i == 8'h31);
    endcase
  end
endmodule

// File: rtl/npar_accum.sv
module npar_accum
  import npar_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  npar_rad_e        rad_i,
  input  logic [3:0]       dig_i,
  output logic [WIDTH-1:0] acc_o,
  output logic             ovf_o
);
  localparam int EXT = WIDTH + 5;

  logic [EXT-1:0] ext, prod, sum;

  always_comb begin
    ext = {5'b0, acc_o};
    unique case (rad_i)
      RAD_HEX: prod = ext << 4;
      RAD_OCT: prod = ext << 3;
      RAD_BIN: prod = ext << 1;
      default: prod = (ext << 3) + (ext << 1);
    endcase
    sum = prod + {{(EXT-4){1'b0}}, dig_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      ovf_o <= 1'b0;
    end else if (load_i) begin
      acc_o <= {{(WIDTH-4){1'b0}}, dig_i};
      ovf_o <= 1'b0;
    end else if (step_i) begin
      acc_o <= sum[WIDTH-1:0];
      ovf_o <= ovf_o | (|sum[EXT-1:WIDTH]);
    end
  end
endmodule

// File: rtl/npar_fsm.sv
module npar_fsm
  import npar_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [7:0]       char_i,
  input  logic             ws_i,
  input  logic             nz_dec_i,
  input  logic             fit_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic             ovf_i,
  output npar_rad_e        rad_o,
  output logic             load_o,
  output logic             step_o,
  output logic             done_o,
  output logic             err_o,
  output logic             m1_o,
  output logic [WIDTH-1:0] val_o
);
  localparam logic [7:0] CH_0 = 8'h30;
  localparam logic [7:0] CH_1 = 8'h31;
  localparam logic [7:0] CH_X = 8'h78;
  localparam logic [7:0] CH_B = 8'h62;
  localparam logic [7:0] CH_MINUS = 8'h2D;

  npar_st_e  st_q, st_d;
  npar_rad_e rad_d;
  logic fin_ok, fin_err, fin_m1;

  always_comb begin
    st_d    = st_q;
    rad_d   = rad_o;
    load_o  = 1'b0;
    step_o  = 1'b0;
    fin_ok  = 1'b0;
    fin_err = 1'b0;
    fin_m1  = 1'b0;
    if (valid_i) begin
      if (ws_i) begin
        st_d = ST_IDLE;
        unique case (st_q)
          ST_IDLE:          ;
          ST_ZERO, ST_NEG1: fin_ok = 1'b1;
          ST_DIG: begin
            fin_ok  = !ovf_i;
            fin_err = ovf_i;
          end
          default:          fin_err = 1'b1;
        endcase
        fin_m1 = (st_q == ST_NEG1);
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (char_i == CH_0) begin
              st_d = ST_ZERO; rad_d = RAD_OCT; load_o = 1'b1;
            end else if (nz_dec_i) begin
              st_d = ST_DIG; rad_d = RAD_DEC; load_o = 1'b1;
            end else if (char_i == CH_MINUS) begin
              st_d = ST_NEG;
            end else begin
              st_d = ST_SKIP;
            end
          end
          ST_ZERO: begin
            if (char_i == CH_X) begin
              st_d = ST_PFX; rad_d = RAD_HEX;
            end else if (char_i == CH_B) begin
              st_d = ST_PFX; rad_d = RAD_BIN;
            end else if (fit_i) begin
              st_d = ST_DIG; load_o = 1'b1;
            end else begin
              st_d = ST_SKIP;
            end
          end
          ST_PFX: begin
            if (fit_i) begin
              st_d = ST_DIG; load_o = 1'b1;
            end else begin
              st_d = ST_SKIP;
            end
          end
          ST_DIG: begin
            if (fit_i) step_o = 1'b1;
            else       st_d = ST_SKIP;
          end
          ST_NEG:  st_d = (char_i == CH_1) ? ST_NEG1 : ST_SKIP;
          default: st_d = ST_SKIP;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rad_o  <= RAD_DEC;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      m1_o   <= 1'b0;
      val_o  <= '0;
    end else begin
      st_q   <= st_d;
      rad_o  <= rad_d;
      done_o <= fin_ok;
      err_o  <= fin_err;
      m1_o   <= fin_m1;
      if (fin_ok) val_o <= fin_m1 ? '1 : acc_i;
    end
  end
endmodule

// File: rtl/num_token_parser.sv
module num_token_parser
  import npar_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             char_valid_i,
  input  logic [7:0]       char_i,
  output logic [WIDTH-1:0] value_o,
  output logic             done_o,
  output logic             minus_one_o,
  output logic             error_o
);
  npar_rad_e        rad;
  logic             ws, nz_dec, fit, load, step, ovf;
  logic [3:0]       dig;
  logic [WIDTH-1:0] acc;

  npar_char_class u_class (
    .char_i   (char_i),
    .rad_i    (rad),
    .ws_o     (ws),
    .nz_dec_o (nz_dec),
    .val_o    (dig),
    .fit_o    (fit)
  );

  npar_accum #(.WIDTH(WIDTH)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .rad_i  (rad),
    .dig_i  (dig),
    .acc_o  (acc),
    .ovf_o  (ovf)
  );

  npar_fsm #(.WIDTH(WIDTH)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (char_valid_i),
    .char_i   (char_i),
    .ws_i     (ws),
    .nz_dec_i (nz_dec),
    .fit_i    (fit),
    .acc_i    (acc),
    .ovf_i    (ovf),
    .rad_o    (rad),
    .load_o   (load),
    .step_o   (step),
    .done_o   (done_o),
    .err_o    (error_o),
    .m1_o     (minus_one_o),
    .val_o    (value_o)
  );
endmodule

// File: rtl/num_token_parser_chk.sv
module num_token_parser_chk
  import npar_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             char_valid_i,
  input logic [7:0]       char_i,
  input logic [WIDTH-1:0] value_o,
  input logic             done_o,
  input logic             minus_one_o,
  input logic             error_o
);
  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o)); // R13

  AST_VALUE_ONLY_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (value_o != $past(value_o)) |-> done_o); // R13

  AST_STROBE_AFTER_WS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || error_o) |-> $past(char_valid_i && is_ws(char_i))); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_MINUS_ONE_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    minus_one_o |-> (done_o && (value_o == '1))); // R6

  AST_IDLE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_valid_i |=> !(done_o || error_o)); // R12
endmodule

bind num_token_parser num_token_parser_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .char_valid_i (char_valid_i),
  .char_i       (char_i),
  .value_o      (value_o),
  .done_o       (done_o),
  .minus_one_o  (minus_one_o),
  .error_o      (error_o)
);

// File: tb/num_token_parser_test.sv
module num_token_parser_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        char_valid_i = 1'b0;
  logic [7:0]  char_i = 8'h00;
  logic [31:0] value_o;
  logic        done_o, minus_one_o, error_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  byte tok[$];
  bit          exp_done = 0, exp_err = 0, exp_m1 = 0;
  logic [31:0] exp_val = '0;
  string       exp_req = "R1";

  always #4 clk_i = ~clk_i;

  num_token_parser uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .char_valid_i (char_valid_i),
    .char_i       (char_i),
    .value_o      (value_o),
    .done_o       (done_o),
    .minus_one_o  (minus_one_o),
    .error_o      (error_o)
  );

  function automatic int dval(input byte c);
    if (c >= "0" && c <= "9") return c - "0";
    if (c >= "a" && c <= "f") return c - "a" + 10;
    if (c >= "A" && c <= "F") return c - "A" + 10;
    return 99;
  endfunction

  function automatic bit is_space(input byte c);
    return c == 8'h20 || c == 8'h09 || c == 8'h0D || c == 8'h0A;
  endfunction

  // whole-token reference: classify, then evaluate
  task automatic eval_tok(output bit err, output bit m1, output logic [31:0] v,
                          output string req);
    int n = tok.size();
    int base = 10;
    int start = 0;
    longint acc = 0;
    bit ovf = 0;
    err = 0; m1 = 0; v = '0; req = "R2";
    if (n == 2 && tok[0] == "-" && tok[1] == "1") begin
      m1 = 1; v = 32'hFFFF_FFFF; req = "R6"; return;
    end
    if (tok[0] == "-") begin err = 1; req = "R6"; return; end
    if (n >= 2 && tok[0] == "0" && (tok[1] == "X" || tok[1] == "B")) begin
      err = 1; req = "R9"; return;
    end
    if (n >= 2 && tok[0] == "0" && tok[1] == "x") begin base = 16; start = 2; req = "R3"; end
    else if (n >= 2 && tok[0] == "0" && tok[1] == "b") begin base = 2; start = 2; req = "R5"; end
    else if (tok[0] == "0" && n > 1) begin base = 8; start = 1; req = "R4"; end
    else if (tok[0] == "0") begin v = '0; req = "R2"; return; end
    else if (tok[0] >= "1" && tok[0] <= "9") begin base = 10; start = 0; end
    else begin err = 1; req = "R8"; return; end
    if (start == n) begin err = 1; req = "R10"; return; end
    for (int i = start; i < n; i++) begin
      int d = dval(tok[i]);
      if (d >= base) begin err = 1; if (req != "R4") req = "R8"; return; end
      acc = acc * base + d;
      if (acc > 64'hFFFF_FFFF) begin ovf = 1; acc = acc & 64'hFFFF_FFFF; end
    end
    if (ovf) begin err = 1; req = "R11"; return; end
    v = acc[31:0];
  endtask

  task automatic model(input bit v, input byte c);
    bit e, m;
    logic [31:0] val;
    string r;
    exp_done = 0; exp_err = 0; exp_m1 = 0; exp_req = "R12";
    if (!v) return;
    if (is_space(c)) begin
      if (tok.size() == 0) return;
      eval_tok(e, m, val, r);
      exp_req = r;
      if (e) exp_err = 1;
      else begin exp_done = 1; exp_m1 = m; exp_val = val; end
      tok.delete();
    end else begin
      tok.push_back(c);
    end
  endtask

  task automatic compare();
    total++;
    if (done_o !== exp_done || error_o !== exp_err || minus_one_o !== exp_m1 ||
        value_o !== exp_val) begin
      bad++;
      $display("FAIL %s: done=%0b err=%0b m1=%0b val=%h expected done=%0b err=%0b m1=%0b val=%h",
               exp_req, done_o, error_o, minus_one_o, value_o,
               exp_done, exp_err, exp_m1, exp_val);
    end
  endtask

  task automatic step_char(input bit v, input byte c);
    @(negedge clk_i);
    compare();
    char_valid_i = v;
    char_i = c;
    model(v, c);
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) step_char(1'b1, s[i]);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog: done=%0b err=%0b expected run to finish", done_o, error_o);
    summary();
  end

  initial begin
    exp_req = "R1";
    repeat (3) @(negedge clk_i);
    compare(); // R1 during reset
    rst_ni = 1'b1;
    step_char(1'b0, 8'h00); // R1 after release
    send_str("  \t\r\n ");                  // R12 leading whitespace
    send_str("42 0 7 ");                    // R2
    send_str("0x1aF 0xDEADBEEF 0xffffffff "); // R3
    send_str("017 0777 08 ");               // R4
    send_str("0b101 0b1111 0b102 ");        // R5
    send_str("-1 -2 -1x - ");               // R6
    send_str("5\t6\r7\n8 ");                // R7 all separators
    send_str("12a3 zz9 0x5g ");             // R8
    send_str("0X5 0B1 ");                   // R9
    send_str("0x 0b\t");                    // R10
    send_str("4294967295 4294967296 0x100000000 0b11111111111111111111111111111111 "); // R11
    // R12: idle cycles with junk inside a token
    step_char(1'b1, "1");
    step_char(1'b0, "9");
    step_char(1'b0, " ");
    step_char(1'b1, "2");
    step_char(1'b1, " ");
    step_char(1'b0, " ");
    send_str("   ");
    // R13: back-to-back tokens, result strobe overlaps next token start
    send_str("99 1 -1 x 3 ");
    repeat (3) step_char(1'b0, 8'h00);
    summary();
  end
endmodule